// File: doc/BRIEF.md
# SPI Master/Slave Controller

This block is an 8-bit serial peripheral controller that sits on a small CPU register bus. One control bit chooses between master and slave operation, and two more bits choose clock polarity and clock phase. In master mode the block generates the serial clock from the system clock through a programmable divider. It drives the serial clock and the outgoing data line, and it samples the incoming line. In slave mode it follows an external clock and an active-low select. It samples the master's data and drives its own reply line only while it is selected.

Every transfer is full duplex. The byte that goes out is replaced in the shift register by the byte that comes in. On completion the received byte is copied to a separate read buffer, so the CPU can still read the last byte while the next one is shifting. The transmit side has no buffer. A CPU write that arrives while a transfer is in progress is thrown away, and a collision flag is raised. A completion flag, which can also drive an interrupt, tells software that a byte has finished. Both flags are cleared by reading the status register.

Top module: `spi_periph`

## Requirements
- R1: The register map is as follows. Address 0 is control: bit0 phase (CPHA), bit1 polarity (CPOL), bit2 master select, bit3 interrupt enable. Address 1 is the clock divider value. Address 2 is status: bit7 done, bit6 collision, all other bits 0. Address 3 writes the transmit byte and reads the read buffer. After reset every register reads 0, `sck_o` is 0 and `irq` is 0. Read data appears on `bus_rdata` on the clock edge that captures the read.
- R2: In master mode, a write to address 3 while idle starts a transfer. The serial clock toggles every DIV+1 system clocks. The first toggle comes DIV+1 clocks after the edge that captures the write. There are exactly 16 toggles, and the serial clock rests at CPOL whenever no transfer is running.
- R3: In master mode, `mosi_o` sends the byte MSB first. With CPHA=0 the MSB is present from the start of the transfer, and each later bit follows an even-numbered toggle. With CPHA=1 each bit appears on an odd-numbered toggle.
- R4: In master mode, `miso_i` is sampled on odd toggles when CPHA=0 and on even toggles when CPHA=1. The done flag is set on the clock of the 16th toggle, and the received byte is then readable at address 3.
- R5: A write to address 3 during a transfer does not change the byte being sent and sets the collision flag.
- R6: Reading status returns the flags and then clears both of them, unless a new event sets a flag on that same clock.
- R7: `irq` is high exactly while the done flag is set and interrupt enable is 1.
- R8: In slave mode with CPHA=0, the slave is busy from the falling edge of `ss_n_i` to its rising edge. `miso_o` carries the MSB of the preloaded byte as soon as the slave is selected, and the following bits change on trailing clock edges.
- R9: In slave mode with CPHA=1, a transfer starts at the first leading clock edge while selected and ends at the 8th sample. The select line may stay low across back-to-back bytes.
- R10: A slave stores the byte in the read buffer and sets done after 8 sample edges. If `ss_n_i` rises before 8 samples, the partial byte is dropped and done stays clear.
- R11: During a transfer, reading address 3 returns the previous completed byte.
- R12: `miso_oe` is high only in slave mode while the synchronized select is low, 2 clocks after `ss_n_i` changes. `sck_oe` and `mosi_oe` equal the master bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Completion interrupt |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data in |

## Verification
The assertions assume that control bits CPOL and master are not rewritten while a master transfer is running, because the idle-level and end-of-transfer properties compare the clock pin against the live polarity bit. They also assume that the external slave clock and select change no faster than the synchronizer can follow. The bench changes the configuration only between transfers. It drives the slave-side lines with half periods of 8 system clocks and changes select only while the external clock is idle.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DIV  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic master;
    logic cpol;
    logic cpha;
  } ctrl_t;

  localparam int CTRL_BITS = 4;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_W = 8,
  parameter int FRAME = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             run,
  output logic             lead,
  output logic             trail,
  output logic             last
);

  localparam int TOG_N = 2 * FRAME;
  localparam int TOG_W = $clog2(TOG_N);

  logic [DIV_W-1:0] cnt;
  logic [TOG_W-1:0] tog;
  logic             fire;

  // one toggle every div+1 clocks; even toggle index is a leading edge
  assign fire  = run && (cnt == div);
  assign lead  = fire && !tog[0];
  assign trail = fire && tog[0];
  assign last  = fire && (tog == TOG_W'(TOG_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
      tog <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      sck <= cpol;
      cnt <= '0;
      tog <= '0;
      if (start) run <= 1'b1;
    end else if (fire) begin
      cnt <= '0;
      sck <= ~sck;
      tog <= tog + 1'b1;
      if (last) run <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int FRAME = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [FRAME-1:0] load_data,
  input  logic             clear,
  input  logic             sample,
  input  logic             launch,
  input  logic             din,
  output logic             obit,
  output logic [FRAME-1:0] rx_data,
  output logic             done
);

  localparam int CNT_W = $clog2(FRAME);

  logic [FRAME-1:0] sh;
  logic [CNT_W-1:0] n;

  assign done    = sample && !clear && (n == CNT_W'(FRAME - 1));
  assign rx_data = {sh[FRAME-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      n    <= '0;
      obit <= 1'b0;
    end else if (load) begin
      sh   <= load_data;
      obit <= load_data[FRAME-1];
      n    <= '0;
    end else begin
      if (clear) begin
        n <= '0;
      end else if (sample) begin
        sh <= {sh[FRAME-2:0], din};
        n  <= done ? '0 : n + 1'b1;
      end
      if (launch) obit <= sh[FRAME-1];
    end
  end

endmodule

// File: rtl/spi_periph.sv
module spi_periph
  import spi_pkg::*;
#(
  parameter int FRAME = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [FRAME-1:0] bus_wdata,
  output logic [FRAME-1:0] bus_rdata,
  output logic             irq,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             sck_i,
  input  logic             ss_n_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             miso_i
);

  localparam int PAD_CTRL = FRAME - CTRL_BITS;

  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [FRAME-1:0] rbuf_q;
  logic             spif, wcol;

  logic cfg_master, cfg_cpol, cfg_cpha, cfg_irq_en;
  assign cfg_master = ctrl_q.master;
  assign cfg_cpol   = ctrl_q.cpol;
  assign cfg_cpha   = ctrl_q.cpha;
  assign cfg_irq_en = ctrl_q.irq_en;

  // bus decode
  logic wr_ctrl, wr_div, data_wr, stat_rd;
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
  assign wr_div  = bus_sel && bus_wr && (bus_addr == REG_DIV);
  assign data_wr = bus_sel && bus_wr && (bus_addr == REG_DATA);
  assign stat_rd = bus_sel && bus_rd && (bus_addr == REG_STAT);

  // slave-side pin synchronisation and edge detection
  logic ss_s, sck_s, mosi_s, sck_d, ss_d;
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n_i, sck_i, mosi_i}),
    .q   ({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      ss_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      ss_d  <= ss_s;
    end
  end

  logic s_sel, s_chg, s_lead, s_trail, ss_fall;
  assign s_sel   = !cfg_master && !ss_s;
  assign s_chg   = sck_s ^ sck_d;
  assign s_lead  = s_sel && s_chg && (sck_s != cfg_cpol);
  assign s_trail = s_sel && s_chg && (sck_s == cfg_cpol);
  assign ss_fall = ss_d && !ss_s;

  // master clock generator
  logic m_sck, m_run, m_lead, m_trail, m_last, m_start;
  spi_sck_gen #(.DIV_W(DIV_W), .FRAME(FRAME)) u_gen (
    .clk   (clk),
    .rst   (rst),
    .start (m_start),
    .cpol  (cfg_cpol),
    .div   (div_q),
    .sck   (m_sck),
    .run   (m_run),
    .lead  (m_lead),
    .trail (m_trail),
    .last  (m_last)
  );

  // slave activity for phase-1 framing
  logic s_act, sh_done;
  always_ff @(posedge clk) begin
    if (rst) begin
      s_act <= 1'b0;
    end else if (!s_sel || sh_done) begin
      s_act <= 1'b0;
    end else if (s_lead && cfg_cpha) begin
      s_act <= 1'b1;
    end
  end

  logic busy;
  always_comb begin
    if (cfg_master)    busy = m_run;
    else if (cfg_cpha) busy = s_act;
    else               busy = !ss_s;
  end

  // edge roles by phase
  logic lead_e, trail_e, sample_e, launch_e, din, load, sh_clear, obit;
  logic [FRAME-1:0] rx_data;
  assign lead_e   = cfg_master ? m_lead  : s_lead;
  assign trail_e  = cfg_master ? m_trail : s_trail;
  assign sample_e = cfg_cpha ? trail_e : lead_e;
  assign launch_e = (cfg_cpha ? lead_e : trail_e) ||
                    (!cfg_master && !cfg_cpha && ss_fall);
  assign din      = cfg_master ? miso_i : mosi_s;
  assign load     = data_wr && !busy;
  assign m_start  = load && cfg_master;
  assign sh_clear = !cfg_master && ss_s;

  spi_shifter #(.FRAME(FRAME)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (bus_wdata),
    .clear     (sh_clear),
    .sample    (sample_e),
    .launch    (launch_e),
    .din       (din),
    .obit      (obit),
    .rx_data   (rx_data),
    .done      (sh_done)
  );

  // flags and registers
  logic spif_set, wcol_set;
  assign spif_set = cfg_master ? m_last : sh_done;
  assign wcol_set = data_wr && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      rbuf_q <= '0;
      spif   <= 1'b0;
      wcol   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      if (wr_div)  div_q  <= DIV_W'(bus_wdata);
      if (sh_done) rbuf_q <= rx_data;
      spif <= spif_set || (spif && !stat_rd);
      wcol <= wcol_set || (wcol && !stat_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && bus_rd) begin
      case (reg_addr_e'(bus_addr))
        REG_CTRL: bus_rdata <= {{PAD_CTRL{1'b0}}, ctrl_q};
        REG_DIV:  bus_rdata <= FRAME'(div_q);
        REG_STAT: bus_rdata <= {spif, wcol, {(FRAME-2){1'b0}}};
        default:  bus_rdata <= rbuf_q;
      endcase
    end
  end

  // pins
  assign irq     = cfg_irq_en && spif;
  assign sck_o   = m_sck;
  assign sck_oe  = cfg_master;
  assign mosi_o  = cfg_master && obit;
  assign mosi_oe = cfg_master;
  assign miso_o  = !cfg_master && obit;
  assign miso_oe = s_sel;

endmodule

// File: rtl/spi_periph_chk.sv
module spi_periph_chk (
  input logic clk,
  input logic rst,
  input logic cfg_master,
  input logic cfg_cpol,
  input logic m_run,
  input logic data_wr,
  input logic busy,
  input logic stat_rd,
  input logic spif,
  input logic spif_set,
  input logic wcol,
  input logic sck_o,
  input logic miso_oe
);

  // R2: serial clock rests at the polarity level when no transfer runs
  a_r2_sck_idle: assert property (@(posedge clk) disable iff (rst)
    (!m_run && $past(!m_run) && $stable(cfg_cpol)) |-> (sck_o == cfg_cpol));

  // R2: after the final toggle the clock is back at idle
  a_r2_end_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(m_run) |-> (sck_o == cfg_cpol));

  // R4: master completion raises done
  a_r4_done_on_end: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $fell(m_run)) |-> spif);

  // R5: write during a transfer flags a collision
  a_r5_collision: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy) |=> wcol);

  // R6: status read clears done unless a new completion arrives
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !spif_set) |=> !spif);

  // R12: reply line is only enabled in slave mode
  a_r12_miso_oe_slave: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> !cfg_master);

endmodule

bind spi_periph spi_periph_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_master (cfg_master),
  .cfg_cpol   (cfg_cpol),
  .m_run      (m_run),
  .data_wr    (data_wr),
  .busy       (busy),
  .stat_rd    (stat_rd),
  .spif       (spif),
  .spif_set   (spif_set),
  .wcol       (wcol),
  .sck_o      (sck_o),
  .miso_oe    (miso_oe)
);

// File: tb/test_spi_periph.sv
`timescale 1ns/1ps
module test_spi_periph;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 0, ss_n_i = 1, mosi_i = 0, miso_i = 0;

  always #10 clk = ~clk;

  spi_periph i_spi_periph (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- behavioural master reference ----------------
  bit   cmp_m = 0, cmp_s = 0;
  bit   m_req = 0, m_on = 0;
  int   m_t = 0, m_tg = 0, nsamp = 0;
  int   cur_div = 0;
  bit   cur_cpol = 0, cur_cpha = 0;
  logic [7:0] m_tx = 0, m_rx = 0;
  logic h1 = 1, h2 = 1;

  always @(posedge clk) begin
    if (m_on) begin
      m_t++;
      m_tg = m_t / (cur_div + 1);
      if (m_tg >= 16) m_on = 0;
    end else if (m_req) begin
      m_on = 1; m_t = 0; m_tg = 0; m_req = 0;
    end
    nsamp = cur_cpha ? m_tg / 2 : (m_tg + 1) / 2;
    h2 = h1;
    h1 = ss_n_i;
  end

  always @(negedge clk) begin
    if (cmp_m) begin
      chk(sck_o, m_on ? (cur_cpol ^ (m_tg % 2)) : cur_cpol, "R2 sck level");
      if (m_on) begin
        int idx;
        idx = cur_cpha ? ((m_tg == 0) ? 0 : (m_tg - 1) / 2) : m_tg / 2;
        chk(mosi_o, m_tx[7-idx], "R3 mosi bit");
      end
      if (!m_on)          miso_i = m_rx[7];
      else if (nsamp < 8) miso_i = m_rx[7-nsamp];
      else                miso_i = 1'b0;
    end
    if (cmp_s) chk(miso_oe, !h2, "R12 miso_oe follows select");
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic m_config(input bit cpol, input bit cpha, input bit ien, input int dv);
    cmp_m = 0;
    cur_cpol = cpol; cur_cpha = cpha; cur_div = dv;
    bus_write(2'd0, {4'b0, ien, 1'b1, cpol, cpha});
    bus_write(2'd1, 8'(dv));
    @(negedge clk);
    cmp_m = 1;
  endtask

  task automatic m_start(input logic [7:0] tx, input logic [7:0] rx);
    @(negedge clk);
    m_tx = tx; m_rx = rx; m_req = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = tx;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic m_wait();
    while (m_on) @(negedge clk);
  endtask

  task automatic m_case(input logic [7:0] tx, input logic [7:0] rx, input string tag);
    logic [7:0] d;
    m_start(tx, rx);
    m_wait();
    bus_read(2'd3, d);
    chk(d, rx, {tag, " R4 received byte"});
    bus_read(2'd2, d);
    chk(d, 8'h80, {tag, " R4 done flag"});
    bus_read(2'd2, d);
    chk(d, 8'h00, {tag, " R6 flags cleared"});
  endtask

  // ---------------- slave-side stimulus ----------------
  task automatic s_bits(input bit cpha, input bit cpol, input logic [7:0] tx,
                        input int nb, output logic [7:0] got);
    got = 8'h00;
    if (!cpha) begin
      mosi_i = tx[7];
      repeat (H) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
        got[7-i] = miso_o;
        sck_i = ~cpol;
        repeat (H) @(negedge clk);
        sck_i = cpol;
        if (i < 7) mosi_i = tx[6-i];
        repeat (H) @(negedge clk);
      end
    end else begin
      for (int i = 0; i < nb; i++) begin
        sck_i = ~cpol;
        mosi_i = tx[7-i];
        repeat (H) @(negedge clk);
        got[7-i] = miso_o;
        sck_i = cpol;
        repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic s_config(input bit cpol, input bit cpha);
    cmp_m = 0;
    sck_i = cpol;
    bus_write(2'd0, {6'b0, cpol, cpha});
    repeat (4) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] d, got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk(sck_o, 0, "R1 reset sck");
    chk(irq, 0, "R1 reset irq");
    chk(miso_oe, 0, "R1 reset miso_oe");
    bus_read(2'd0, d); chk(d, 8'h00, "R1 reset ctrl");
    bus_read(2'd1, d); chk(d, 8'h00, "R1 reset div");
    bus_read(2'd2, d); chk(d, 8'h00, "R1 reset status");
    bus_read(2'd3, d); chk(d, 8'h00, "R1 reset data");

    // master, cpol0 cpha0, fastest clock
    m_config(0, 0, 0, 0);
    bus_read(2'd0, d); chk(d, 8'h04, "R1 ctrl readback");
    chk(sck_oe, 1, "R12 sck_oe in master");
    chk(mosi_oe, 1, "R12 mosi_oe in master");
    m_case(8'hA5, 8'h96, "m00");

    // master, cpol1 cpha1, irq, collision and double buffer
    m_config(1, 1, 1, 2);
    bus_read(2'd1, d); chk(d, 8'h02, "R1 div readback");
    m_start(8'h3C, 8'h5A);
    repeat (10) @(negedge clk);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, d); chk(d, 8'h96, "R11 read buffer holds previous byte");
    chk(irq, 0, "R7 irq low while running");
    m_wait();
    chk(irq, 1, "R7 irq with done and enable");
    bus_read(2'd3, d); chk(d, 8'h5A, "R4 received byte m11");
    bus_read(2'd2, d); chk(d, 8'hC0, "R5 collision and done flags");
    chk(irq, 0, "R7 irq cleared by status read");
    bus_read(2'd2, d); chk(d, 8'h00, "R6 flags cleared m11");

    // remaining master modes
    m_config(0, 1, 0, 1);
    m_case(8'hC3, 8'h3C, "m01");
    m_config(1, 0, 0, 3);
    m_case(8'h01, 8'h80, "m10");
    cmp_m = 0;

    // slave cpha0 cpol0 with collision
    s_config(0, 0);
    chk(sck_oe, 0, "R12 sck_oe in slave");
    cmp_s = 1;
    bus_write(2'd3, 8'hA5);
    @(negedge clk); ss_n_i = 0;
    repeat (4) @(negedge clk);
    bus_write(2'd3, 8'hFF);
    s_bits(0, 0, 8'h3C, 8, got);
    chk(got, 8'hA5, "R8 slave reply unaffected by collision (R5)");
    ss_n_i = 1;
    repeat (H) @(negedge clk);
    bus_read(2'd3, d); chk(d, 8'h3C, "R10 slave received byte");
    bus_read(2'd2, d); chk(d, 8'hC0, "R5 slave collision with done");

    // slave cpha0 cpol1, then partial frame
    s_config(1, 0);
    bus_write(2'd3, 8'h69);
    @(negedge clk); ss_n_i = 0;
    s_bits(0, 1, 8'hE1, 8, got);
    chk(got, 8'h69, "R8 slave reply cpol1");
    ss_n_i = 1;
    repeat (H) @(negedge clk);
    bus_read(2'd3, d); chk(d, 8'hE1, "R10 slave byte cpol1");
    bus_read(2'd2, d); chk(d, 8'h80, "R10 slave done");
    bus_write(2'd3, 8'h0F);
    @(negedge clk); ss_n_i = 0;
    s_bits(0, 1, 8'h55, 3, got);
    ss_n_i = 1;
    repeat (H) @(negedge clk);
    bus_read(2'd2, d); chk(d, 8'h00, "R10 partial frame sets nothing");
    bus_read(2'd3, d); chk(d, 8'hE1, "R10 partial frame keeps buffer");

    // slave cpha1, select held low across two bytes
    s_config(0, 1);
    bus_write(2'd3, 8'h5A);
    @(negedge clk); ss_n_i = 0;
    repeat (H) @(negedge clk);
    s_bits(1, 0, 8'h81, 8, got);
    chk(got, 8'h5A, "R9 first byte reply");
    bus_read(2'd3, d); chk(d, 8'h81, "R9 first byte received");
    bus_read(2'd2, d); chk(d, 8'h80, "R9 first byte done");
    bus_write(2'd3, 8'hC3);
    s_bits(1, 0, 8'h7E, 8, got);
    chk(got, 8'hC3, "R9 second byte reply");
    bus_read(2'd3, d); chk(d, 8'h7E, "R9 second byte received");
    bus_read(2'd2, d); chk(d, 8'h80, "R9 second byte done no collision");
    ss_n_i = 1;
    repeat (H) @(negedge clk);
    cmp_s = 0;

    summary();
  end

endmodule